// File: doc/BRIEF.md
# Handshake Debug Register Target

This block is a small register bank that answers a debug-module request bus in the system clock domain. A master raises `req` and drives an address, write data and a write flag alongside it. The target accepts the request in the first cycle it sees `req` high while `ack` is low. In that cycle it performs one read or one write. After a configurable number of wait cycles it raises `ack`, with the response data on `din`.

The response is a full four-phase level handshake. The target keeps `ack` high and `din` unchanged for as long as `req` stays high. This holds even if `req` never falls, and the access is not repeated. Once the master lowers `req`, the target drops `ack` and becomes ready for the next request.

The bank holds a power-of-two number of registers, selected by the low address bits. Any address above the bank reads as zero, and writes to such an address are acknowledged without effect.

Top module: `dbg_reg_target`

## Requirements
- R1: A synchronous active-high reset forces `ack` low and clears every register, so a read of any in-range address after reset returns zero.
- R2: `wr` = 1 selects a write and `wr` = 0 selects a read. A write stores `dout` into the register with index `addr[3:0]` (16 registers by default), and a read never changes register contents.
- R3: A request is accepted on the first rising edge where `req` is high and `ack` is low. `ack` rises exactly WAIT_CYC clock edges after that acceptance edge (default WAIT_CYC = 2), and WAIT_CYC = 0 makes `ack` rise at the acceptance edge itself.
- R4: While `req` stays high, `ack` stays high for any length of time and the access is performed only once.
- R5: For a read, `din` carries the addressed register's value when `ack` rises and stays constant for the whole time `ack` is high.
- R6: `ack` falls on the clock edge that samples `req` low while `ack` is high.
- R7: A new request raised in the cycle right after `ack` falls is accepted without any extra idle cycle and follows the same timing as R3.
- R8: An address of 16 or more (any bit above the index bits set) reads as zero, and a write to it is acknowledged but changes no register.
- R9: For a write, `din` returns the register's value from before the write (zero for an out-of-range address).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request level from the master |
| wr | input | 1 | Access type: 1 write, 0 read |
| addr | input | ADDR_W (8) | Register address, valid with the rising `req` |
| dout | input | DATA_W (32) | Write data from the master |
| ack | output | 1 | Acknowledge level, held until `req` falls |
| din | output | DATA_W (32) | Response data to the master |

## Verification
The hardest case to reach from the ports is a request whose `req` stays high far longer than the handshake needs. In that case the target must neither re-accept nor let `din` drift. The bench holds `req` high for dozens of cycles after `ack` and checks `ack` and `din` on every one of those cycles. It then reads the register back, so that a second write or a changed result would be exposed. Out-of-range addresses that share low bits with a live register are also written. A read of the aliased register then shows that the write was discarded.

// File: rtl/dbg_tgt_pkg.sv
package dbg_tgt_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dbg_tgt_hs.sv
module dbg_tgt_hs #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic ack
);
  import dbg_tgt_pkg::*;

  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam int LOAD  = (WAIT_CYC > 0) ? WAIT_CYC - 1 : 0;

  hs_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ack_q;

  // one access per handshake: only from idle with ack low
  assign accept = (state_q == HS_IDLE) && req;
  assign ack    = ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          if (req) begin
            if (WAIT_CYC == 0) begin
              state_q <= HS_HOLD;
              ack_q   <= 1'b1;
            end else begin
              state_q <= HS_WAIT;
              cnt_q   <= CNT_W'(LOAD);
            end
          end
        end
        HS_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= HS_HOLD;
            ack_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        HS_HOLD: begin
          if (!req) begin
            state_q <= HS_IDLE;
            ack_q   <= 1'b0;
          end
        end
        default: begin
          state_q <= HS_IDLE;
          ack_q   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_tgt_regfile.sv
module dbg_tgt_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic              in_range,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [REG_CNT];
  logic [DATA_W-1:0] rdata_q;

  assign rdata = rdata_q;

  // read-first port: the response shows contents from before the write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) mem[idx] <= wdata;
      if (re) rdata_q <= in_range ? mem[idx] : '0;
    end
  end
endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_CNT  = 16,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dout,
  output logic              ack,
  output logic [DATA_W-1:0] din
);
  localparam int IDX_W = $clog2(REG_CNT);

  logic accept;
  logic in_range;

  generate
    if (ADDR_W > IDX_W) begin : g_range
      assign in_range = ~|addr[ADDR_W-1:IDX_W];
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  dbg_tgt_hs #(
    .WAIT_CYC(WAIT_CYC)
  ) u_hs (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .accept (accept),
    .ack    (ack)
  );

  dbg_tgt_regfile #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (accept && wr && in_range),
    .re       (accept),
    .in_range (in_range),
    .idx      (addr[IDX_W-1:0]),
    .wdata    (dout),
    .rdata    (din)
  );
endmodule

// File: rtl/dbg_tgt_chk.sv
module dbg_tgt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ack,
  input logic [DATA_W-1:0] din
);
  // R1
  reset_ack_low_chk: assert property (@(posedge clk) $past(rst) |-> !ack);

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> !ack);

  // R5
  din_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> $stable(din));

  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(req));
endmodule

bind dbg_reg_target dbg_tgt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk (clk),
  .rst (rst),
  .req (req),
  .ack (ack),
  .din (din)
);

// File: tb/sim_dbg_reg_target.sv
`timescale 1ns/1ps
module sim_dbg_reg_target;
  localparam int AW = 8, DW = 32, NREG = 16, WC = 2;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dout = '0;
  logic ack;
  logic [DW-1:0] din;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NREG];

  always #2.5 clk = ~clk;

  dbg_reg_target #(.ADDR_W(AW), .DATA_W(DW), .REG_CNT(NREG), .WAIT_CYC(WC)) u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .dout(dout),
    .ack(ack), .din(din)
  );

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one full handshake; req raised at a falling edge, checks inside
  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold);
    int lat = 0;
    bit inr = (a < NREG);
    logic [DW-1:0] exp = inr ? model[a[3:0]] : '0;
    logic [DW-1:0] first;
    wr = w; addr = a; dout = d; req = 1'b1;
    forever begin
      @(negedge clk);
      if (ack || lat > 50) break;
      lat++;
    end
    chk(lat == WC, "R3 ack latency", DW'(lat), DW'(WC));
    if (w) chk(din == exp, "R9 write returns old value", din, exp);
    else   chk(din == exp, inr ? "R5 read data" : "R8 out-of-range read zero", din, exp);
    if (w && inr) model[a[3:0]] = d;
    first = din;
    addr = ~a; dout = ~d; wr = ~w;  // bus may change while ack held
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ack == 1'b1, "R4 ack held while req high", DW'(ack), 1);
      chk(din == first, "R5 din stable while ack high", din, first);
    end
    req = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R6 ack falls after req low", DW'(ack), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ack == 1'b0, "R1 ack low after reset", DW'(ack), 0);
    for (int i = 0; i < NREG; i += 5) access(1'b0, AW'(i), '0, 1); // R1 zeroed
  endtask

  task automatic t_write_read;  // R2
    access(1'b1, 8'h03, 32'hA5A5_0103, 1);
    access(1'b0, 8'h03, '0, 2);
    access(1'b1, 8'h0F, 32'hDEAD_BEEF, 0);
    access(1'b0, 8'h0F, '0, 1);
    access(1'b0, 8'h0F, '0, 1); // R2 read does not modify
    access(1'b1, 8'h03, 32'h1234_5678, 1); // R9 returns A5A5_0103
    access(1'b0, 8'h03, '0, 1);
  endtask

  task automatic t_long_hold;   // R4 single access while req stays high
    access(1'b1, 8'h07, 32'h0000_0077, 40);
    access(1'b0, 8'h07, '0, 40);
  endtask

  task automatic t_out_of_range; // R8
    access(1'b1, 8'h13, 32'hCCCC_CCCC, 1);
    access(1'b0, 8'h03, '0, 1);
    access(1'b0, 8'h13, '0, 1);
    access(1'b1, 8'hF0, 32'h1111_1111, 1);
    access(1'b0, 8'h00, '0, 1);
  endtask

  task automatic t_back_to_back; // R7 no idle gap between handshakes
    for (int i = 0; i < 6; i++) access(i[0], AW'(8 + i), DW'(32'h5000 + i), 0);
    for (int i = 8; i < 14; i++) access(1'b0, AW'(i), '0, 0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_long_hold();
    t_out_of_range();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule